// File: doc/BRIEF.md
# Memory Region Permission Checker

This block decides whether a single memory access may proceed, given a set of protection regions that are already decoded into inclusive start and end byte addresses. Each region carries read, write and execute permission bits, a lock bit and an active flag. A request presents an access address, a byte count, the set of permissions it needs and whether it comes from machine mode or from a lower privilege mode. The block returns one allow or deny bit, registered one clock after the request.

Regions are ranked by index, and index 0 has the highest priority. The first byte and the last byte of the access are both compared against every active region. The lowest-indexed region that contains either byte alone decides the outcome. If the access straddles that region's edge, the access is refused. If the access lies wholly inside it, the region's permission bits apply. A machine-mode access skips those bits unless the region is locked. When no region claims the access, machine mode is allowed and lower modes are refused. When no region is active at all, every access is allowed.

Top module: `pmp_access_checker`

## Requirements
- R1: When no entry has its active flag set, every request is allowed, in either privilege mode and for any permission set.
- R2: Among active entries that contain the first or the last byte of the access, the entry with the lowest index alone decides the result. Entries with higher indices are ignored.
- R3: An entry whose active flag is clear never matches, whatever its bounds and permission bits.
- R4: The last byte address is the access address plus the byte count minus one. A byte count of 0 is treated as 1. A last byte that carries past the top of the address space lies inside no entry.
- R5: If exactly one of the first and last bytes lies inside the deciding entry, the request is denied.
- R6: For an access fully inside the deciding entry, a machine-mode request to an unlocked entry is granted read, write and execute.
- R7: For an access fully inside the deciding entry, in lower mode or when that entry is locked, the allowed set is the entry's permission field. The field encodes read in bit 0, write in bit 1 and execute in bit 2. The request is allowed only if every requested bit is in that set.
- R8: If at least one entry is active and none matches, a machine-mode request is allowed and a lower-mode request is denied.
- R9: `rsp_valid` equals `req_valid` from the previous clock. `rsp_allow` gives the decision for the request of the previous clock and holds its value in cycles without a request. Both outputs are 0 out of reset.
- R10: Entry bounds are inclusive. An access whose first byte equals the start, or whose last byte equals the end, counts as inside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Address of the first byte of the access |
| req_size | input | SIZE_W | Byte count of the access (0 treated as 1) |
| req_perm | input | 3 | Requested permissions: bit 0 read, bit 1 write, bit 2 execute |
| req_machine | input | 1 | 1 = machine mode, 0 = lower privilege mode |
| ent_start | input | ENTRIES*ADDR_W | Inclusive start address per entry, entry i in bits [i*ADDR_W +: ADDR_W] |
| ent_end | input | ENTRIES*ADDR_W | Inclusive end address per entry, same packing |
| ent_perm | input | ENTRIES*3 | Permission field per entry, entry i in bits [i*3 +: 3] |
| ent_lock | input | ENTRIES | Lock bit per entry |
| ent_active | input | ENTRIES | Active flag per entry |
| rsp_valid | output | 1 | Decision for the previous cycle's request is present |
| rsp_allow | output | 1 | 1 = allowed, 0 = denied |

## Verification
Requests go to a set of regions in which two entries overlap. A low-index read-only entry sits inside a larger read-write entry, so the index order, not the permissive outer region, is shown to decide. Accesses that touch a boundary exactly are compared with accesses that cross it by one byte, which separates inclusive bounds from partial overlap. A wrap past the top of the address space is also tried. The same address is tried in both privilege modes against a locked entry, an unlocked entry, an inactive entry and empty space. This shows apart the machine-mode bypass, the effect of the lock, skipped inactive entries and the fallback when no entry matches.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;
  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;

  typedef logic [PERM_W-1:0] perm_t;

  typedef struct packed {
    logic capture;
    logic allow;
  } ctrl_strobe_t;
endpackage

// File: rtl/pmpchk_datapath.sv
module pmpchk_datapath
  import pmpchk_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [SIZE_W-1:0]         req_size,
  input  logic [ENTRIES*ADDR_W-1:0] ent_start,
  input  logic [ENTRIES*ADDR_W-1:0] ent_end,
  input  logic [ENTRIES-1:0]        ent_active,
  input  ctrl_strobe_t              strobe,
  output logic [ENTRIES-1:0]        firstIn,
  output logic [ENTRIES-1:0]        lastIn,
  output logic                      rsp_valid,
  output logic                      rsp_allow
);
  localparam int WIDE_W = ADDR_W + 1;

  logic [WIDE_W-1:0] sizeEff;
  logic [WIDE_W-1:0] lastWide;
  logic              lastOver;
  logic [ADDR_W-1:0] lastAddr;

  // last byte = first + size - 1, one extra bit catches the carry out of the space
  assign sizeEff  = (req_size == '0) ? WIDE_W'(1) : WIDE_W'(req_size);
  assign lastWide = {1'b0, req_addr} + sizeEff - WIDE_W'(1);
  assign lastOver = lastWide[ADDR_W];
  assign lastAddr = lastWide[ADDR_W-1:0];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    assign lo = ent_start[gi*ADDR_W +: ADDR_W];
    assign hi = ent_end[gi*ADDR_W +: ADDR_W];
    assign firstIn[gi] = (req_addr >= lo) && (req_addr <= hi);
    assign lastIn[gi]  = !lastOver && (lastAddr >= lo) && (lastAddr <= hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= strobe.capture;
      if (strobe.capture) rsp_allow <= strobe.allow;
    end
  end

  // R9: response follows request by one cycle
  p_resp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9: idle cycles keep the last decision
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_allow)));
  // R1: nothing active means everything passes
  p_no_rules_allow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ent_active == '0) |=> rsp_allow);
  // R4: carry past the top places the last byte in no entry
  p_wrap_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_addr} + sizeEff > {1'b0, {ADDR_W{1'b1}}} + WIDE_W'(1))) |-> (lastIn == '0));
endmodule

// File: rtl/pmpchk_control.sv
module pmpchk_control
  import pmpchk_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  perm_t                     req_perm,
  input  logic                      req_machine,
  input  logic [ENTRIES*PERM_W-1:0] ent_perm,
  input  logic [ENTRIES-1:0]        ent_lock,
  input  logic [ENTRIES-1:0]        ent_active,
  input  logic [ENTRIES-1:0]        firstIn,
  input  logic [ENTRIES-1:0]        lastIn,
  output ctrl_strobe_t              strobe
);
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] winner;
  logic               found;
  logic               selFirst;
  logic               selLast;
  logic               selLock;
  perm_t              selPerm;
  perm_t              grantSet;
  logic               anyActive;
  logic               decision;

  assign hitVec    = ent_active & (firstIn | lastIn);
  assign anyActive = |ent_active;

  // lowest index wins
  always_comb begin
    winner = '0;
    found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i] && !found) begin
        winner[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    selPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (winner[i]) selPerm = selPerm | ent_perm[i*PERM_W +: PERM_W];
    end
  end

  assign selFirst = |(winner & firstIn);
  assign selLast  = |(winner & lastIn);
  assign selLock  = |(winner & ent_lock);
  assign grantSet = (req_machine && !selLock) ? PERM_ALL : selPerm;

  always_comb begin
    if (!anyActive)              decision = 1'b1;
    else if (!found)             decision = req_machine;
    else if (selFirst ^ selLast) decision = 1'b0;
    else                         decision = ((req_perm & ~grantSet) == '0);
  end

  assign strobe.capture = req_valid;
  assign strobe.allow   = decision;

  // R2: at most one entry decides
  p_single_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(winner));
  // R5: a straddle of entry 0 is refused
  p_partial_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ent_active[0] && (firstIn[0] != lastIn[0])) |-> !strobe.allow);
  // R8: fallback depends on the mode only
  p_nomatch_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && anyActive && hitVec == '0) |-> (strobe.allow == req_machine));
  // R6: machine mode inside unlocked entry 0 always passes
  p_machine_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_machine && ent_active[0] && !ent_lock[0] && firstIn[0] && lastIn[0])
      |-> strobe.allow);
endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmpchk_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [SIZE_W-1:0]         req_size,
  input  logic [2:0]                req_perm,
  input  logic                      req_machine,
  input  logic [ENTRIES*ADDR_W-1:0] ent_start,
  input  logic [ENTRIES*ADDR_W-1:0] ent_end,
  input  logic [ENTRIES*3-1:0]      ent_perm,
  input  logic [ENTRIES-1:0]        ent_lock,
  input  logic [ENTRIES-1:0]        ent_active,
  output logic                      rsp_valid,
  output logic                      rsp_allow
);
  logic [ENTRIES-1:0] firstIn;
  logic [ENTRIES-1:0] lastIn;
  ctrl_strobe_t       strobe;

  pmpchk_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .ent_start  (ent_start),
    .ent_end    (ent_end),
    .ent_active (ent_active),
    .strobe     (strobe),
    .firstIn    (firstIn),
    .lastIn     (lastIn),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow)
  );

  pmpchk_control #(.ENTRIES(ENTRIES)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_perm    (req_perm),
    .req_machine (req_machine),
    .ent_perm    (ent_perm),
    .ent_lock    (ent_lock),
    .ent_active  (ent_active),
    .firstIn     (firstIn),
    .lastIn      (lastIn),
    .strobe      (strobe)
  );
endmodule

// File: tb/pmp_access_checker_test.sv
`timescale 1ns/1ps
module pmp_access_checker_test;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [2:0] req_perm = '0;
  logic req_machine = 1'b0;
  logic [AW-1:0] eS [N];
  logic [AW-1:0] eE [N];
  logic [2:0] eP [N];
  logic [N-1:0] eL = '0;
  logic [N-1:0] eA = '0;
  logic [N*AW-1:0] startF, endF;
  logic [N*3-1:0] permF;
  logic rsp_valid, rsp_allow;

  int checks = 0;
  int fails = 0;
  string curTag = "R9";
  logic monOn = 1'b0;
  logic mValid, mAllow;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      startF[i*AW +: AW] = eS[i];
      endF[i*AW +: AW]   = eE[i];
      permF[i*3 +: 3]    = eP[i];
    end
  end

  pmp_access_checker #(.ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_machine(req_machine),
    .ent_start(startF), .ent_end(endF), .ent_perm(permF), .ent_lock(eL),
    .ent_active(eA), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );

  // behavioural reference
  function automatic logic refAllow();
    longint last;
    logic f, l;
    logic [2:0] grant;
    if (eA == '0) return 1'b1;
    last = longint'(req_addr) + ((req_size == 0) ? 64'd1 : longint'(req_size)) - 1;
    for (int i = 0; i < N; i++) begin
      if (!eA[i]) continue;
      f = (req_addr >= eS[i]) && (req_addr <= eE[i]);
      l = (last <= longint'(32'hFFFF_FFFF)) && (last >= longint'(eS[i])) && (last <= longint'(eE[i]));
      if (f && l) begin
        grant = (req_machine && !eL[i]) ? 3'b111 : eP[i];
        return ((req_perm & grant) == req_perm);
      end
      if (f || l) return 1'b0;
    end
    return req_machine;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mValid <= 1'b0;
      mAllow <= 1'b0;
    end else begin
      mValid <= req_valid;
      if (req_valid) mAllow <= refAllow();
    end
  end

  always @(negedge clk) begin
    if (monOn) begin
      checks++;
      if (rsp_valid !== mValid || rsp_allow !== mAllow) begin
        fails++;
        $display("FAIL %s model: valid=%0b allow=%0b expected valid=%0b allow=%0b",
                 curTag, rsp_valid, rsp_allow, mValid, mAllow);
      end
    end
  end

  task automatic runReq(input string tag, input logic [AW-1:0] a, input logic [SW-1:0] s,
                        input logic [2:0] p, input logic m, input logic exp);
    @(negedge clk);
    curTag = tag; req_valid = 1'b1; req_addr = a; req_size = s; req_perm = p; req_machine = m;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_allow !== exp) begin
      fails++;
      $display("FAIL %s: valid=%0b allow=%0b expected valid=1 allow=%0b", tag, rsp_valid, rsp_allow, exp);
    end
  endtask

  task automatic setEnt(input int i, input logic [AW-1:0] s, input logic [AW-1:0] e,
                        input logic [2:0] p, input logic lk, input logic act);
    eS[i] = s; eE[i] = e; eP[i] = p; eL[i] = lk; eA[i] = act;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) setEnt(i, '0, '0, 3'b000, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: valid=%0b allow=%0b expected 0 0", rsp_valid, rsp_allow);
    end
    monOn = 1'b1;

    // R1: no active entries
    runReq("R1", 32'h0000_1234, 8'd4, 3'b100, 1'b0, 1'b1);
    runReq("R1", 32'h0000_8000, 8'd1, 3'b011, 1'b1, 1'b1);

    @(negedge clk);
    req_valid = 1'b0;
    setEnt(0, 32'h0000_1000, 32'h0000_10FF, 3'b001, 1'b0, 1'b1);
    setEnt(1, 32'h0000_1000, 32'h0000_1FFF, 3'b011, 1'b0, 1'b1);
    setEnt(2, 32'h0000_8000, 32'h0000_8FFF, 3'b001, 1'b1, 1'b1);
    setEnt(3, 32'h0000_4000, 32'h0000_4FFF, 3'b111, 1'b0, 1'b0);
    setEnt(4, 32'hFFFF_FF00, 32'hFFFF_FFFF, 3'b111, 1'b0, 1'b1);

    // R2: overlap, lowest index decides
    runReq("R2", 32'h0000_1010, 8'd4, 3'b010, 1'b0, 1'b0);
    runReq("R2", 32'h0000_1200, 8'd4, 3'b010, 1'b0, 1'b1);
    runReq("R2", 32'h0000_1010, 8'd4, 3'b001, 1'b0, 1'b1);
    // R5: straddle at end of entry 0
    runReq("R5", 32'h0000_10FE, 8'd4, 3'b001, 1'b0, 1'b0);
    // R10: inclusive bounds
    runReq("R10", 32'h0000_1000, 8'd1, 3'b001, 1'b0, 1'b1);
    runReq("R10", 32'h0000_1001, 8'hFF, 3'b001, 1'b0, 1'b1);
    // R6: machine bypass of unlocked entry
    runReq("R6", 32'h0000_1010, 8'd4, 3'b110, 1'b1, 1'b1);
    // R7: locked entry binds machine mode; subset rule
    runReq("R7", 32'h0000_8010, 8'd4, 3'b010, 1'b1, 1'b0);
    runReq("R7", 32'h0000_8010, 8'd4, 3'b001, 1'b1, 1'b1);
    runReq("R7", 32'h0000_8010, 8'd4, 3'b100, 1'b0, 1'b0);
    runReq("R7", 32'h0000_1500, 8'd8, 3'b011, 1'b0, 1'b1);
    runReq("R7", 32'h0000_1500, 8'd8, 3'b111, 1'b0, 1'b0);
    // R3: inactive entry skipped
    runReq("R3", 32'h0000_4010, 8'd4, 3'b001, 1'b0, 1'b0);
    runReq("R3", 32'h0000_4010, 8'd4, 3'b001, 1'b1, 1'b1);
    // R8: no match fallback
    runReq("R8", 32'h0000_9000, 8'd4, 3'b001, 1'b0, 1'b0);
    runReq("R8", 32'h0000_9000, 8'd4, 3'b100, 1'b1, 1'b1);
    // R4: size zero, carry over edge, top wrap
    runReq("R4", 32'h0000_10FF, 8'd0, 3'b001, 1'b0, 1'b1);
    runReq("R4", 32'h0000_10FF, 8'd2, 3'b001, 1'b0, 1'b0);
    runReq("R4", 32'hFFFF_FFFE, 8'd4, 3'b001, 1'b0, 1'b0);
    runReq("R4", 32'hFFFF_FFFC, 8'd4, 3'b001, 1'b0, 1'b1);

    // R9: hold without request
    @(negedge clk);
    curTag = "R9";
    req_valid = 1'b0;
    req_machine = 1'b0;
    req_addr = 32'h0000_9000;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b1) begin
      fails++;
      $display("FAIL R9 hold: valid=%0b allow=%0b expected valid=0 allow=1", rsp_valid, rsp_allow);
    end

    monOn = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule